// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line-Break Detection

This block turns an asynchronous serial input line into a stream of received characters. A programmable divisor sets a sampling tick of one pulse every `divisor` clocks. Sixteen ticks make one bit time. The receiver checks each falling edge as a possible start bit and samples every later bit at its centre. It then assembles 5 to 8 data bits, least significant bit first. If enabled, it checks an even or odd parity bit, and it checks the first stop bit. Each finished character goes into a 64-entry receive queue with three status flags: parity error, framing error and line break.

The queue drains through a valid/ready stream port. `out_valid` is high whenever the queue holds a character, and it shows the oldest one. A character leaves the queue only on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head character and its flags stay unchanged, however many characters arrive behind it. The receiver cannot be stalled, so a character that arrives while the queue is full is dropped and `overrun` pulses.

With automatic flow control enabled, `rts` follows the queue fill level with hysteresis, so the remote transmitter pauses before the queue overflows. With the queue disabled, the block works as a single holding register.

Top module: `serial_rx_engine`

## Requirements
- R1: The sampling tick fires once every `divisor` clocks, and a divisor of 0 acts as 1. One bit lasts 16 ticks, so characters sent at 16×divisor clocks per bit are received correctly for any divisor.
- R2: A low level on the line counts as a start bit only if the line is still low at the 8th tick after the falling edge was seen. A shorter low pulse produces no character.
- R3: `char_len` selects 5, 6, 7 or 8 data bits (encodings 0, 1, 2, 3). Data arrives least significant bit first, and `out_data` bits above the character length read 0.
- R4: With `parity_en`=1, one parity bit follows the data. `parity_odd`=0 expects an even number of ones over the data and parity bit, and `parity_odd`=1 expects an odd number. A mismatch sets `out_parity_err` for that character.
- R5: If the first stop bit is sampled as 0, `out_frame_err` is set for that character. The receiver then accepts no new start bit until the line has been seen high.
- R6: A frame in which the start bit, every data bit, the parity bit (if present) and the stop bit are all 0 is a line break. It stores one character with data 0, `out_break`=1, `out_frame_err`=1 and `out_parity_err`=0. A continuous low level, however long, yields only that one character.
- R7: With `fifo_en`=1 the queue holds 64 characters; with `fifo_en`=0 it holds one. Characters leave in arrival order, one per edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head character and its flags stay stable.
- R8: A character that completes while the queue is full is discarded, the stored characters are unchanged, and `overrun` is high for exactly one clock.
- R9: With `auto_flow_en`=1, `rts` goes low the clock after the fill level reaches 56 or more. It goes high again the clock after the level is below 48, and between those marks it keeps its value. With `auto_flow_en`=0, `rts` is high.
- R10: After reset, `out_valid`=0, `overrun`=0 and `rts`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Clocks per sampling tick (0 treated as 1) |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| auto_flow_en | input | 1 | Drive `rts` from the queue level |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| out_valid | output | 1 | Head character present |
| out_ready | input | 1 | Consumer accepts the head character |
| out_data | output | 8 | Head character data, right aligned |
| out_parity_err | output | 1 | Parity mismatch on head character |
| out_frame_err | output | 1 | Stop bit was 0 on head character |
| out_break | output | 1 | Head character is a line break |
| overrun | output | 1 | One-clock pulse: character dropped, queue full |
| rts | output | 1 | Request to send; high = remote may transmit |

## Verification
On every cycle, the checker confirms that the head of the stream stays unchanged under back-pressure and that the fill level never exceeds the queue depth. It also confirms that a break character always reads as zero with a framing error, that `overrun` never lasts two clocks, and that `rts` follows the high and low marks and the manual setting. The directed scenarios are the only way to show the serial behaviour itself. These include data recovered at different divisors and character lengths, parity verdicts and rejected start glitches. They also include one break character for a long low level, a dropped character on overflow, and the arrival order across a full queue.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } srx_char_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (divisor == '0) ? '0 : divisor - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  output logic       push,
  output srx_char_t  pchar
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

  logic            rx_m, rx_s;
  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [2:0]      bidx;
  logic [7:0]      shreg;
  logic            pbit;
  logic [2:0]      last_idx;
  logic [7:0]      aligned;
  logic            sample;
  logic            brk_hit;
  srx_char_t       nxt;

  // two-stage synchronizer, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  assign last_idx = 3'd4 + {1'b0, char_len};
  assign aligned  = shreg >> (2'd3 - char_len);
  assign sample   = tick && (cnt == BIT_LAST);

  always_comb begin
    brk_hit  = !rx_s && (aligned == 8'h00) && !(parity_en && pbit);
    nxt.data = aligned;
    nxt.perr = parity_en && ((^aligned ^ pbit) != parity_odd);
    nxt.ferr = !rx_s;
    nxt.brk  = brk_hit;
    if (brk_hit) nxt.perr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      push  <= 1'b0;
      pchar <= '0;
    end else begin
      push <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (tick && !rx_s) st <= RX_START;
        end
        RX_START: begin
          if (tick) begin
            if (cnt == MID_LAST) begin
              cnt  <= '0;
              bidx <= '0;
              pbit <= 1'b0;
              st   <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (sample) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bidx == last_idx) st <= parity_en ? RX_PAR : RX_STOP;
            else bidx <= bidx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (sample) begin
            cnt  <= '0;
            pbit <= rx_s;
            st   <= RX_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (sample) begin
            cnt   <= '0;
            push  <= 1'b1;
            pchar <= nxt;
            st    <= rx_s ? RX_IDLE : RX_WAIT_HI;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_WAIT_HI: begin
          cnt <= '0;
          if (tick && rx_s) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             wr,
  input  srx_char_t        wdata,
  output logic             rd_valid,
  input  logic             rd_ready,
  output srx_char_t        rdata,
  output logic [CNT_W-1:0] level,
  output logic             overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  srx_char_t        mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap;
  logic             full, acc, pop;

  assign cap      = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (cnt >= cap);
  assign acc      = wr && !full;
  assign rd_valid = (cnt != '0);
  assign pop      = rd_valid && rd_ready;
  assign rdata    = mem[rptr];
  assign level    = cnt;

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= wr && full;
      if (acc) wptr <= nxt_ptr(wptr);
      if (pop) rptr <= nxt_ptr(rptr);
      case ({acc, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/srx_flow.sv
module srx_flow #(
  parameter int CNT_W = 7,
  parameter int HI    = 56,
  parameter int LO    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic [CNT_W-1:0] level,
  output logic             rts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rts <= 1'b1;
    else if (!auto_en)                rts <= 1'b1;
    else if (level >= CNT_W'(HI))     rts <= 1'b0;
    else if (level <  CNT_W'(LO))     rts <= 1'b1;
  end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import srx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16,
  parameter int DEPTH = 64,
  parameter int HI    = 56,
  parameter int LO    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             fifo_en,
  input  logic             auto_flow_en,
  input  logic             rx_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_parity_err,
  output logic             out_frame_err,
  output logic             out_break,
  output logic             overrun,
  output logic             rts
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             tick;
  logic             push;
  srx_char_t        pchar;
  srx_char_t        head;
  logic [CNT_W-1:0] fifo_count;

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  srx_deser #(.OSR(OSR)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
    .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .push(push), .pchar(pchar)
  );

  srx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr(push), .wdata(pchar),
    .rd_valid(out_valid), .rd_ready(out_ready), .rdata(head),
    .level(fifo_count), .overrun(overrun)
  );

  srx_flow #(.CNT_W(CNT_W), .HI(HI), .LO(LO)) u_flow (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_flow_en), .level(fifo_count), .rts(rts)
  );

  assign out_data       = head.data;
  assign out_parity_err = head.perr;
  assign out_frame_err  = head.ferr;
  assign out_break      = head.brk;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7,
  parameter int HI    = 56,
  parameter int LO    = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_flow_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_parity_err,
  input logic             out_frame_err,
  input logic             out_break,
  input logic             overrun,
  input logic             rts,
  input logic [CNT_W-1:0] level
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_parity_err)
      && $stable(out_frame_err) && $stable(out_break)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R7
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    level == '0 |-> !out_valid); // R7
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_break |-> out_data == 8'h00 && out_frame_err && !out_parity_err); // R6
  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun); // R8
  AST_MANUAL_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_flow_en |=> rts); // R9
  AST_RTS_HIGH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    auto_flow_en && level >= CNT_W'(HI) |=> !rts); // R9
  AST_RTS_LOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    auto_flow_en && level < CNT_W'(LO) |=> rts); // R9
endmodule

bind serial_rx_engine srx_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .HI(HI), .LO(LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_flow_en(auto_flow_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_parity_err(out_parity_err), .out_frame_err(out_frame_err),
  .out_break(out_break), .overrun(overrun), .rts(rts), .level(fifo_count)
);

// File: tb/serial_rx_engine_test.sv
module serial_rx_engine_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  char_len = 2'd3;
  logic        parity_en = 1'b0, parity_odd = 1'b0;
  logic        fifo_en = 1'b1, auto_flow_en = 1'b0;
  logic        rx_in = 1'b1;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_parity_err, out_frame_err, out_break, overrun, rts;

  int total = 0, bad = 0, ovr_seen = 0;
  bit done = 0;

  serial_rx_engine uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .char_len(char_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .fifo_en(fifo_en),
    .auto_flow_en(auto_flow_en), .rx_in(rx_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_parity_err(out_parity_err),
    .out_frame_err(out_frame_err), .out_break(out_break), .overrun(overrun), .rts(rts)
  );

  always #(CLK_P / 2) clk = ~clk;

  always @(negedge clk) if (rst_n && overrun) ovr_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bit_time();
    return 16 * ((divisor == 0) ? 1 : int'(divisor)) * CLK_P;
  endfunction

  // drive one frame; nb data bits, optional parity, chosen stop level
  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit podd, input bit bad_par, input bit stop_v);
    logic p = podd;
    rx_in = 1'b0;
    #(bit_time());
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      p ^= d[i];
      #(bit_time());
    end
    if (pen) begin
      rx_in = p ^ bad_par;
      #(bit_time());
    end
    rx_in = stop_v;
    #(bit_time());
    rx_in = 1'b1;
    #(bit_time());
  endtask

  task automatic wait_char(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (out_valid) begin got = 1; break; end
    end
  endtask

  task automatic pop_one();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_char(input string req, input logic [7:0] d,
                             input bit pe, input bit fe, input bit bk);
    bit got;
    wait_char(got);
    chk(got, {req, " valid"}, int'(got), 1);
    chk(out_data == d, {req, " data"}, int'(out_data), int'(d));
    chk(out_parity_err == pe, {req, " perr"}, int'(out_parity_err), int'(pe));
    chk(out_frame_err == fe, {req, " ferr"}, int'(out_frame_err), int'(fe));
    chk(out_break == bk, {req, " break"}, int'(out_break), int'(bk));
    pop_one();
    chk(!out_valid, {req, " drained"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid, "R10 valid", int'(out_valid), 0);
    chk(!overrun, "R10 overrun", int'(overrun), 0);
    chk(rts, "R10 rts", int'(rts), 1);
  endtask

  task automatic t_divisors();
    divisor = 16'd1; char_len = 2'd3;
    send_frame(8'hA5, 8, 0, 0, 0, 1);
    expect_char("R1 R3 div1", 8'hA5, 0, 0, 0);
    divisor = 16'd3;
    send_frame(8'h3C, 8, 0, 0, 0, 1);
    expect_char("R1 div3", 8'h3C, 0, 0, 0);
    divisor = 16'd0;
    send_frame(8'h81, 8, 0, 0, 0, 1);
    expect_char("R1 div0", 8'h81, 0, 0, 0);
    divisor = 16'd1;
  endtask

  task automatic t_lengths();
    char_len = 2'd0;
    send_frame(8'hF5, 5, 0, 0, 0, 1);
    expect_char("R3 len5", 8'h15, 0, 0, 0);
    char_len = 2'd2;
    send_frame(8'hFF, 7, 0, 0, 0, 1);
    expect_char("R3 len7", 8'h7F, 0, 0, 0);
    char_len = 2'd3;
  endtask

  task automatic t_parity();
    parity_en = 1; parity_odd = 0;
    send_frame(8'h13, 8, 1, 0, 0, 1);
    expect_char("R4 even ok", 8'h13, 0, 0, 0);
    send_frame(8'h13, 8, 1, 0, 1, 1);
    expect_char("R4 even bad", 8'h13, 1, 0, 0);
    parity_odd = 1;
    send_frame(8'h6E, 8, 1, 1, 0, 1);
    expect_char("R4 odd ok", 8'h6E, 0, 0, 0);
    send_frame(8'h6E, 8, 1, 1, 1, 1);
    expect_char("R4 odd bad", 8'h6E, 1, 0, 0);
    parity_en = 0; parity_odd = 0;
  endtask

  task automatic t_framing();
    send_frame(8'h55, 8, 0, 0, 0, 0);
    expect_char("R5 stop low", 8'h55, 0, 1, 0);
    send_frame(8'h2A, 8, 0, 0, 0, 1);
    expect_char("R5 recovers", 8'h2A, 0, 0, 0);
  endtask

  task automatic t_glitch();
    int o = ovr_seen;
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    #(20 * bit_time());
    chk(!out_valid, "R2 glitch rejected", int'(out_valid), 0);
    chk(ovr_seen == o, "R2 no overrun", ovr_seen, o);
  endtask

  task automatic t_break();
    parity_en = 1;
    rx_in = 1'b0;
    #(40 * bit_time());
    rx_in = 1'b1;
    #(3 * bit_time());
    expect_char("R6 break", 8'h00, 0, 1, 1);
    #(5 * bit_time());
    chk(!out_valid, "R6 single break char", int'(out_valid), 0);
    parity_en = 0;
  endtask

  task automatic t_hold();
    bit got;
    send_frame(8'hC3, 8, 0, 0, 0, 1);
    wait_char(got);
    repeat (25) @(negedge clk);
    chk(out_valid && out_data == 8'hC3, "R7 head held", int'(out_data), 8'hC3);
    pop_one();
  endtask

  task automatic t_single_reg();
    int o;
    fifo_en = 0;
    o = ovr_seen;
    send_frame(8'h11, 8, 0, 0, 0, 1);
    send_frame(8'h22, 8, 0, 0, 0, 1);
    chk(ovr_seen == o + 1, "R8 overrun pulse", ovr_seen, o + 1);
    chk(out_data == 8'h11, "R8 kept first", int'(out_data), 8'h11);
    pop_one();
    chk(!out_valid, "R7 depth one", int'(out_valid), 0);
    fifo_en = 1;
  endtask

  task automatic t_fill();
    int o;
    auto_flow_en = 1;
    for (int i = 0; i < 56; i++) begin
      send_frame(8'(i), 8, 0, 0, 0, 1);
      if (i == 54) chk(rts, "R9 rts at 55", int'(rts), 1);
    end
    chk(!rts, "R9 rts off at 56", int'(rts), 0);
    for (int i = 56; i < 64; i++) send_frame(8'(i), 8, 0, 0, 0, 1);
    o = ovr_seen;
    send_frame(8'hEE, 8, 0, 0, 0, 1);
    chk(ovr_seen == o + 1, "R8 full overrun", ovr_seen, o + 1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == 8'(i), "R7 order", int'(out_data), i);
      pop_one();
      if (i == 15) chk(!rts, "R9 rts held at 48", int'(rts), 0);
      if (i == 16) begin
        @(negedge clk);
        chk(rts, "R9 rts back at 47", int'(rts), 1);
      end
    end
    chk(!out_valid, "R8 dropped char absent", int'(out_valid), 0);
    for (int i = 0; i < 60; i++) send_frame(8'h5A, 8, 0, 0, 0, 1);
    chk(!rts, "R9 rts off again", int'(rts), 0);
    auto_flow_en = 0;
    repeat (2) @(negedge clk);
    chk(rts, "R9 manual rts", int'(rts), 1);
    for (int i = 0; i < 60; i++) pop_one();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divisors();
    t_lengths();
    t_parity();
    t_framing();
    t_glitch();
    t_break();
    t_hold();
    t_single_reg();
    t_fill();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule